// File: doc/BRIEF.md
# PCI Slot Interrupt Router with Legacy Mapping Detection

This block takes the four level-sensitive interrupt pins (INTA to INTD) of each of several PCI slots and merges them onto four system interrupt outputs. A pin's output is chosen by a rotation that depends on the slot number and on a static board-variant select. The two supported board variants wire their connectors differently, so their rotation offsets differ. Each output is the OR of every pin currently routed to it.

Older host software expects an identity mapping with no slot rotation. To support it, the block snoops configuration-space writes. It watches for writes to the interrupt-line register and uses the value written there to settle, once per reset, whether the host expects the legacy identity mapping or the correct rotation. This detection runs only on the first board variant. The current mode is brought out on a port.

Top module: `pci_irq_router`

## Requirements
- R1: In any cycle with `rst` high, the `mode` register is set to assume-correct at the clock edge. The mode encoding is 0 = assume-correct, 1 = legacy, 2 = forced-correct.
- R2: Once `mode` is legacy or forced-correct, it keeps that value until the next reset, whatever writes follow.
- R3: When `variant_b` = 1, `mode` stays at assume-correct. Slot s pin p (0 = INTA to 3 = INTD) then drives output (s + p + 3) mod 4. For example, slot 31 INTA drives output 2.
- R4: A snooped write qualifies only when all of the following hold: `cfg_wr` is high, `cfg_addr[7:0]` = 0x3C, `variant_b` = 0 and `mode` is assume-correct. Any other write, and any cycle with `cfg_wr` low, leaves `mode` unchanged.
- R5: The slot number of a write is `cfg_addr[15:11]`. The function bits `cfg_addr[10:8]` play no part in the decision.
- R6: A qualifying write whose slot number mod 4 equals 2 leaves `mode` unchanged.
- R7: Any other qualifying write sets `mode` at the next clock edge. It goes to legacy when `cfg_data[7:0]` = 27, whatever the upper data bits are, and to forced-correct for any other byte.
- R8: In legacy mode, pin p of every slot drives output p.
- R9: When `variant_b` = 0 and the mode is assume-correct or forced-correct, slot s pin p drives output (s + p + 2) mod 4. For example, slot 31 INTA drives output 1 and slot 29 INTA drives output 3.
- R10: Each output is the OR of all pins routed to it. The outputs follow the pins and `mode` combinationally, so a mode change re-routes them in the same cycle that `mode` changes. Pin bit 4*i + p of `slot_int` is pin p of slot FIRST_SLOT + i. With the defaults, FIRST_SLOT = 28 and there are 4 slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_b | input | 1 | Static board variant select: 0 = first variant, 1 = second variant |
| slot_int | input | 4*NUM_SLOTS | Interrupt pins; bit 4*i + p is pin p of slot FIRST_SLOT + i |
| cfg_wr | input | 1 | Strobe for a snooped configuration write |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_data | input | DATA_W | Configuration write data |
| sys_irq | output | 4 | System interrupt levels |
| mode | output | 2 | Current mapping mode |

## Verification
Mode detection and interrupt routing can act in the same cycle. A pin stays asserted while a qualifying write lands, and at the clock edge the pin's output moves to its new position. The bench holds slot 31 INTA high and writes 27 to that slot's interrupt-line register. It expects output 1 before the edge and output 0 right after it. Full sweeps of single pins in each mode and variant, together with pseudo-random multi-pin patterns, judge the routing arithmetic against the rotation formulas.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;

    typedef enum logic [1:0] {
        MODE_ASSUME = 2'd0,
        MODE_LEGACY = 2'd1,
        MODE_FORCED = 2'd2
    } route_mode_t;

    localparam int PINS_PER_SLOT = 4;
    localparam int NUM_OUTPUTS   = 4;
    localparam int SLOT_W        = 5;

    typedef struct packed {
        logic              strobe;
        logic [SLOT_W-1:0] slot;
        logic [7:0]        offset;
        logic [7:0]        low_byte;
    } snoop_t;

    // Output index for one pin of one slot
    function automatic logic [1:0] route_index(
        input logic [SLOT_W-1:0] slot,
        input logic [1:0]        pin,
        input logic              var_b,
        input route_mode_t       mode
    );
        logic [1:0] offs;
        if (!var_b && mode == MODE_LEGACY)
            return pin;
        offs = var_b ? 2'd3 : 2'd2;
        return slot[1:0] + pin + offs;
    endfunction

endpackage

// File: rtl/irq_mode_tracker.sv
module irq_mode_tracker
    import pci_irq_router_pkg::*;
#(
    parameter logic [7:0] LINE_OFFSET = 8'h3C,
    parameter logic [7:0] LEGACY_CODE = 8'd27
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        variant_b,
    input  snoop_t      snoop,
    output route_mode_t mode
);

    route_mode_t mode_q;
    logic        hits_line;
    logic        slot_differs;
    logic        take;

    assign hits_line    = snoop.strobe && (snoop.offset == LINE_OFFSET);
    assign slot_differs = (snoop.slot[1:0] != 2'd2);
    assign take         = hits_line && !variant_b && (mode_q == MODE_ASSUME) && slot_differs;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_ASSUME;
        else if (take)
            mode_q <= (snoop.low_byte == LEGACY_CODE) ? MODE_LEGACY : MODE_FORCED;
    end

    assign mode = mode_q;

    a_r1_reset_assume: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mode_q == MODE_ASSUME);

    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_ASSUME) |=> $stable(mode_q));

    a_r3_variant_b_hold: assert property (@(posedge clk) disable iff (rst)
        variant_b |=> mode_q == MODE_ASSUME);

    a_r4_ignore_other: assert property (@(posedge clk) disable iff (rst)
        !hits_line |=> $stable(mode_q));

    a_r6_slot_two: assert property (@(posedge clk) disable iff (rst)
        (snoop.strobe && snoop.slot[1:0] == 2'd2) |=> $stable(mode_q));

    a_r7_legacy_code: assert property (@(posedge clk) disable iff (rst)
        (hits_line && !variant_b && mode_q == MODE_ASSUME && snoop.slot[1:0] != 2'd2
         && snoop.low_byte == LEGACY_CODE) |=> mode_q == MODE_LEGACY);

    a_r7_other_code: assert property (@(posedge clk) disable iff (rst)
        (hits_line && !variant_b && mode_q == MODE_ASSUME && snoop.slot[1:0] != 2'd2
         && snoop.low_byte != LEGACY_CODE) |=> mode_q == MODE_FORCED);

    a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
        mode_q != route_mode_t'(2'd3));

endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
    import pci_irq_router_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int FIRST_SLOT = 28
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               variant_b,
    input  route_mode_t                        mode,
    input  logic [PINS_PER_SLOT*NUM_SLOTS-1:0] slot_int,
    output logic [NUM_OUTPUTS-1:0]             sys_irq
);

    logic [NUM_OUTPUTS-1:0] contrib [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [SLOT_W-1:0] SLOT_NUM = SLOT_W'(FIRST_SLOT + i);
        always_comb begin
            contrib[i] = '0;
            for (int p = 0; p < PINS_PER_SLOT; p++) begin
                if (slot_int[PINS_PER_SLOT*i + p])
                    contrib[i][route_index(SLOT_NUM, 2'(p), variant_b, mode)] = 1'b1;
            end
        end
    end

    always_comb begin
        sys_irq = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            sys_irq = sys_irq | contrib[i];
    end

    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        (slot_int == '0) |-> (sys_irq == '0));

    a_r10_reaches_out: assert property (@(posedge clk) disable iff (rst)
        (slot_int != '0) |-> (sys_irq != '0));

    a_r10_bounded: assert property (@(posedge clk) disable iff (rst)
        $countones(sys_irq) <= $countones(slot_int));

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pci_irq_router_pkg::*;
#(
    parameter int         NUM_SLOTS   = 4,
    parameter int         FIRST_SLOT  = 28,
    parameter int         ADDR_W      = 24,
    parameter int         DATA_W      = 32,
    parameter logic [7:0] LINE_OFFSET = 8'h3C,
    parameter logic [7:0] LEGACY_CODE = 8'd27
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               variant_b,
    input  logic [PINS_PER_SLOT*NUM_SLOTS-1:0] slot_int,
    input  logic                               cfg_wr,
    input  logic [ADDR_W-1:0]                  cfg_addr,
    input  logic [DATA_W-1:0]                  cfg_data,
    output logic [NUM_OUTPUTS-1:0]             sys_irq,
    output logic [1:0]                         mode
);

    localparam int SLOT_LSB = 11;

    snoop_t      snoop;
    route_mode_t cur_mode;

    assign snoop.strobe   = cfg_wr;
    assign snoop.slot     = cfg_addr[SLOT_LSB +: SLOT_W];
    assign snoop.offset   = cfg_addr[7:0];
    assign snoop.low_byte = cfg_data[7:0];

    irq_mode_tracker #(
        .LINE_OFFSET(LINE_OFFSET),
        .LEGACY_CODE(LEGACY_CODE)
    ) u_tracker (
        .clk      (clk),
        .rst      (rst),
        .variant_b(variant_b),
        .snoop    (snoop),
        .mode     (cur_mode)
    );

    irq_slot_router #(
        .NUM_SLOTS (NUM_SLOTS),
        .FIRST_SLOT(FIRST_SLOT)
    ) u_router (
        .clk      (clk),
        .rst      (rst),
        .variant_b(variant_b),
        .mode     (cur_mode),
        .slot_int (slot_int),
        .sys_irq  (sys_irq)
    );

    assign mode = cur_mode;

endmodule

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;

    localparam int NS = 4;
    localparam int FS = 28;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          variant_b = 1'b0;
    logic [4*NS-1:0] slot_int = '0;
    logic          cfg_wr = 1'b0;
    logic [23:0]   cfg_addr = '0;
    logic [31:0]   cfg_data = '0;
    logic [3:0]    sys_irq;
    logic [1:0]    mode;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pci_irq_router uut (
        .clk(clk), .rst(rst), .variant_b(variant_b), .slot_int(slot_int),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .sys_irq(sys_irq), .mode(mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] line_addr(input int slot, input int fn, input logic [7:0] off);
        return 24'((slot << 11) | (fn << 8) | off);
    endfunction

    function automatic logic [3:0] expect_out(input logic [4*NS-1:0] pins, input bit vb, input bit legacy);
        logic [3:0] r = '0;
        for (int i = 0; i < NS; i++)
            for (int p = 0; p < 4; p++)
                if (pins[4*i+p]) begin
                    if (legacy && !vb) r[p] = 1'b1;
                    else r[(FS + i + p + (vb ? 3 : 2)) % 4] = 1'b1;
                end
        return r;
    endfunction

    task automatic do_reset(input bit vb);
        @(negedge clk);
        rst = 1'b1; variant_b = vb; cfg_wr = 1'b0; slot_int = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic cfg_write(input logic [23:0] a, input logic [31:0] d, input bit strobe);
        @(negedge clk);
        cfg_addr = a; cfg_data = d; cfg_wr = strobe;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic sweep(input string req, input bit vb, input bit legacy);
        for (int i = 0; i < NS; i++)
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                slot_int = '0;
                slot_int[4*i+p] = 1'b1;
                #1;
                check(req, 32'(sys_irq), 32'(expect_out(slot_int, vb, legacy)));
            end
        @(negedge clk);
        slot_int = '0;
        #1;
    endtask

    task automatic mix(input string req, input bit vb, input bit legacy, input logic [15:0] seed);
        logic [15:0] lfsr = seed;
        for (int k = 0; k < 32; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(negedge clk);
            slot_int = lfsr[4*NS-1:0];
            #1;
            check(req, 32'(sys_irq), 32'(expect_out(slot_int, vb, legacy)));
        end
        @(negedge clk);
        slot_int = '0;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b0);
        check("R1 mode after reset", 32'(mode), 32'd0);
        check("R10 idle outputs", 32'(sys_irq), 32'd0);

        // R9: rotation while assuming correct
        sweep("R9 assume rotation", 1'b0, 1'b0);
        @(negedge clk); slot_int = 16'h0001 << 12; #1;
        check("R9 slot31 INTA", 32'(sys_irq), 32'b0010);
        @(negedge clk); slot_int = 16'h0001 << 4; #1;
        check("R9 slot29 INTA", 32'(sys_irq), 32'b1000);
        @(negedge clk); slot_int = '0; #1;

        // R4: non-qualifying writes
        cfg_write(line_addr(28, 0, 8'h3D), 32'd27, 1'b1);
        check("R4 wrong offset", 32'(mode), 32'd0);
        cfg_write(line_addr(28, 0, 8'h3C), 32'd27, 1'b0);
        check("R4 no strobe", 32'(mode), 32'd0);
        // R6: slot 30 never decides
        cfg_write(line_addr(30, 0, 8'h3C), 32'd27, 1'b1);
        check("R6 slot30 value 27", 32'(mode), 32'd0);
        cfg_write(line_addr(30, 0, 8'h3C), 32'd9, 1'b1);
        check("R6 slot30 value 9", 32'(mode), 32'd0);

        // R7 + R5: low byte 27 with upper bits, function bits set
        cfg_write(line_addr(31, 3, 8'h3C), 32'h0000_011B, 1'b1);
        check("R7 R5 legacy detect", 32'(mode), 32'd1);
        sweep("R8 legacy identity", 1'b0, 1'b1);
        mix("R8 R10 legacy mix", 1'b0, 1'b1, 16'hACE1);
        // R2: sticky
        cfg_write(line_addr(28, 0, 8'h3C), 32'd5, 1'b1);
        check("R2 legacy sticky", 32'(mode), 32'd1);

        // R7: forced-correct
        do_reset(1'b0);
        check("R1 mode after second reset", 32'(mode), 32'd0);
        cfg_write(line_addr(29, 0, 8'h3C), 32'd26, 1'b1);
        check("R7 forced detect", 32'(mode), 32'd2);
        sweep("R9 forced rotation", 1'b0, 1'b0);
        mix("R9 R10 forced mix", 1'b0, 1'b0, 16'h1D2B);
        cfg_write(line_addr(31, 0, 8'h3C), 32'd27, 1'b1);
        check("R2 forced sticky", 32'(mode), 32'd2);

        // R10: mode change and routing in the same cycle
        do_reset(1'b0);
        @(negedge clk);
        slot_int = 16'h0001 << 12;
        cfg_addr = line_addr(31, 0, 8'h3C); cfg_data = 32'd27; cfg_wr = 1'b1;
        #1;
        check("R10 before edge", 32'(sys_irq), 32'b0010);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        check("R10 mode after edge", 32'(mode), 32'd1);
        check("R10 rerouted after edge", 32'(sys_irq), 32'b0001);
        @(negedge clk); slot_int = '0; #1;

        // R3: second variant
        do_reset(1'b1);
        sweep("R3 variant b rotation", 1'b1, 1'b0);
        cfg_write(line_addr(31, 0, 8'h3C), 32'd27, 1'b1);
        check("R3 variant b mode held", 32'(mode), 32'd0);
        cfg_write(line_addr(29, 0, 8'h3C), 32'd4, 1'b1);
        check("R3 variant b mode held again", 32'(mode), 32'd0);
        @(negedge clk); slot_int = 16'h0001 << 12; #1;
        check("R3 slot31 INTA", 32'(sys_irq), 32'b0100);
        @(negedge clk); slot_int = 16'h0001 << 8; #1;
        check("R3 slot30 INTA", 32'(sys_irq), 32'b0010);
        mix("R3 R10 variant b mix", 1'b1, 1'b0, 16'h7777);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule